// File: doc/BRIEF.md
# Reset Cause and Request Controller

This block collects reset requests from hardware sources and from software, and turns them into two classes of reset pulse. The hardware sources are an external reset pin, a brownout-high detector, a watchdog, a debugger and the core's system-reset request. A true power-on input acts as the block's own synchronous reset. Software starts either reset class by writing an 8-bit key to a dedicated register. A watchdog request or a brownout condition only resets the chip when its bit in the configuration register is set.

A sticky cause register records every source that has requested a reset since it was last cleared. It keeps its contents through every reset this block issues, so firmware can read after restart why the chip came back. The block also holds a static reset level for the trace port. A brownout interrupt has its own enable, status, set and clear registers.

All registers sit on a simple word-addressed bus with separate read and write strobes. Read data is registered.

Top module: `rcc_top`

## Requirements
- R1: While `por_i` is high, the cause register becomes exactly 0x02 (only bit 1, power-on). The configuration register, the trace reset, the interrupt enable and the interrupt status all become 0. `poi_rst_o` is 0 and `por_rst_o` is 1 on the edge after `por_i` is sampled high.
- R2: A write to offset 0x008 whose low byte is 0xD4 makes `por_rst_o` high for exactly one cycle, starting on the edge that takes the write, and sets cause bit 3. Any other low-byte value has no effect. Bits above the low byte are ignored.
- R3: A write to offset 0x004 whose low byte is 0x1B makes `poi_rst_o` high for exactly one cycle, starting on the edge that takes the write, and sets cause bit 4. Any other value has no effect, and this key never raises `por_rst_o`.
- R4: `ext_rst_i` sets cause bit 0 and `sys_req_i` sets cause bit 3, and each raises `por_rst_o` one edge later. `dbg_req_i` sets cause bit 5 and raises `poi_rst_o` one edge later.
- R5: `wdt_req_i` sets cause bit 6 and raises `por_rst_o` only when configuration bit 1 (offset 0x000) is set. Otherwise it has no effect.
- R6: `bod_i` sets cause bit 2 and raises `por_rst_o` only when configuration bit 0 is set. Otherwise it has no effect on either.
- R7: Cause bits stay set until a write of 1 to bit 0 of offset 0x010 clears all of them at once. A write of 0 there changes nothing. A source that is active in the same cycle as the clear keeps its bit set.
- R8: Bit 0 of offset 0x014 drives `trc_rst_o` as a static level: writing 1 asserts it and writing 0 releases it.
- R9: The interrupt status (bit 0 at 0x204) is set by a rising edge of `bod_i` or by writing 1 to bit 0 of 0x20C. It is cleared by writing 1 to bit 0 of 0x208, and a set in the same cycle wins. `bod_irq_o` equals the status ANDed with the enable (bit 0 at 0x200), whatever the configuration bits are.
- R10: A read returns its data on `rdata_o` one edge after the `rd_en_i` cycle, and `rdata_o` is 0 in any cycle that follows a cycle without a read. Offsets 0x000, 0x00C, 0x014, 0x200 and 0x204 return their register contents. Every other offset, including the key, clear, interrupt-clear and interrupt-set registers, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | True power-on, synchronous active-high reset of all state |
| ext_rst_i | input | 1 | External reset request, level |
| bod_i | input | 1 | Brownout-high detect, level |
| wdt_req_i | input | 1 | Watchdog reset request, level |
| dbg_req_i | input | 1 | Debugger reset request, level |
| sys_req_i | input | 1 | Core system-reset request, level |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| por_rst_o | output | 1 | Power-on-class reset pulse |
| poi_rst_o | output | 1 | Power-on-initialization-class reset pulse |
| trc_rst_o | output | 1 | Static trace-port reset |
| bod_irq_o | output | 1 | Brownout interrupt |

## Verification
The bench uses the default widths: a 12-bit offset, 32-bit data and an 8-bit key. These are small enough that both key registers can be swept over all 256 low-byte values, and every word offset from 0x000 to 0xFFC can be read. The sweeps prove that exactly one key value fires each reset class. They also prove that every unmapped or write-only offset reads zero while all live registers hold non-zero values. All four combinations of the two configuration enables are crossed with the watchdog and brownout requests, and the clear-versus-set collisions are driven on purpose for both the cause register and the interrupt status.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned OFS_W = 12;

  localparam logic [OFS_W-1:0] A_CFG      = 12'h000;
  localparam logic [OFS_W-1:0] A_POI_KEY  = 12'h004;
  localparam logic [OFS_W-1:0] A_POR_KEY  = 12'h008;
  localparam logic [OFS_W-1:0] A_CAUSE    = 12'h00C;
  localparam logic [OFS_W-1:0] A_CAUSE_CL = 12'h010;
  localparam logic [OFS_W-1:0] A_TRC      = 12'h014;
  localparam logic [OFS_W-1:0] A_IRQ_EN   = 12'h200;
  localparam logic [OFS_W-1:0] A_IRQ_ST   = 12'h204;
  localparam logic [OFS_W-1:0] A_IRQ_CLR  = 12'h208;
  localparam logic [OFS_W-1:0] A_IRQ_SET  = 12'h20C;

  // cause register bit positions
  localparam int unsigned CAUSE_N = 7;
  localparam int unsigned C_EXT = 0;
  localparam int unsigned C_PWR = 1;
  localparam int unsigned C_BOD = 2;
  localparam int unsigned C_SWR = 3;
  localparam int unsigned C_POI = 4;
  localparam int unsigned C_DBG = 5;
  localparam int unsigned C_WDT = 6;

  typedef struct packed {
    logic wdt_en;  // bit 1
    logic bod_en;  // bit 0
  } cfg_t;
endpackage

// File: rtl/rcc_key_match.sv
module rcc_key_match #(
  parameter int unsigned KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = '0
) (
  input  logic             wr_hit,
  input  logic [KEY_W-1:0] key_byte,
  output logic             match
);
  assign match = wr_hit && (key_byte == KEY);
endmodule

// File: rtl/rcc_cause_latch.sv
module rcc_cause_latch #(
  parameter int unsigned N = 7,
  parameter logic [N-1:0] PWR_MASK = '0
) (
  input  logic         clk,
  input  logic         por,
  input  logic [N-1:0] set_vec,
  input  logic         clr_all,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (por)             bit_q <= PWR_MASK[i];
      else if (set_vec[i]) bit_q <= 1'b1;   // a live source beats the clear
      else if (clr_all)    bit_q <= 1'b0;
    end
    assign stat[i] = bit_q;
  end
endmodule

// File: rtl/rcc_bod_irq.sv
module rcc_bod_irq (
  input  logic clk,
  input  logic por,
  input  logic bod_i,
  input  logic en_wr,
  input  logic set_wr,
  input  logic clr_wr,
  input  logic wbit,
  output logic en_q,
  output logic st_q,
  output logic irq_o
);
  logic bod_d;
  logic rise;

  assign rise = bod_i && !bod_d;

  always_ff @(posedge clk) begin
    if (por) begin
      bod_d <= 1'b0;
      en_q  <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      bod_d <= bod_i;
      if (en_wr) en_q <= wbit;
      if (rise || (set_wr && wbit)) st_q <= 1'b1;
      else if (clr_wr && wbit)      st_q <= 1'b0;
    end
  end

  assign irq_o = en_q && st_q;
endmodule

// File: rtl/rcc_top.sv
module rcc_top
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned KEY_W  = 8,
  parameter logic [KEY_W-1:0] POI_KEY = 'h1B,
  parameter logic [KEY_W-1:0] POR_KEY = 'hD4
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              ext_rst_i,
  input  logic              bod_i,
  input  logic              wdt_req_i,
  input  logic              dbg_req_i,
  input  logic              sys_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              por_rst_o,
  output logic              poi_rst_o,
  output logic              trc_rst_o,
  output logic              bod_irq_o
);
  localparam int unsigned CN = CAUSE_N;
  localparam logic [CN-1:0] PWR_MASK = CN'(1) << C_PWR;

  // write decode
  logic hit_cfg, hit_poi, hit_por, hit_clr, hit_trc;
  logic hit_ien, hit_iclr, hit_iset;
  assign hit_cfg  = wr_en_i && (addr_i == ADDR_W'(A_CFG));
  assign hit_poi  = wr_en_i && (addr_i == ADDR_W'(A_POI_KEY));
  assign hit_por  = wr_en_i && (addr_i == ADDR_W'(A_POR_KEY));
  assign hit_clr  = wr_en_i && (addr_i == ADDR_W'(A_CAUSE_CL));
  assign hit_trc  = wr_en_i && (addr_i == ADDR_W'(A_TRC));
  assign hit_ien  = wr_en_i && (addr_i == ADDR_W'(A_IRQ_EN));
  assign hit_iclr = wr_en_i && (addr_i == ADDR_W'(A_IRQ_CLR));
  assign hit_iset = wr_en_i && (addr_i == ADDR_W'(A_IRQ_SET));

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:KEY_W];

  // configuration and trace reset
  cfg_t cfg_q;
  logic trc_q;
  always_ff @(posedge clk) begin
    if (por_i) begin
      cfg_q <= '0;
      trc_q <= 1'b0;
    end else begin
      if (hit_cfg) cfg_q <= cfg_t'(wdata_i[1:0]);
      if (hit_trc) trc_q <= wdata_i[0];
    end
  end

  // software keys
  logic poi_match, por_match;
  rcc_key_match #(.KEY_W(KEY_W), .KEY(POI_KEY)) u_poi_key (
    .wr_hit(hit_poi), .key_byte(wdata_i[KEY_W-1:0]), .match(poi_match)
  );
  rcc_key_match #(.KEY_W(KEY_W), .KEY(POR_KEY)) u_por_key (
    .wr_hit(hit_por), .key_byte(wdata_i[KEY_W-1:0]), .match(por_match)
  );

  // gated hardware sources
  logic bod_go, wdt_go;
  assign bod_go = bod_i && cfg_q.bod_en;
  assign wdt_go = wdt_req_i && cfg_q.wdt_en;

  // cause register
  logic [CN-1:0] set_vec;
  logic [CN-1:0] stat_q;
  always_comb begin
    set_vec        = '0;
    set_vec[C_EXT] = ext_rst_i;
    set_vec[C_BOD] = bod_go;
    set_vec[C_SWR] = por_match || sys_req_i;
    set_vec[C_POI] = poi_match;
    set_vec[C_DBG] = dbg_req_i;
    set_vec[C_WDT] = wdt_go;
  end

  rcc_cause_latch #(.N(CN), .PWR_MASK(PWR_MASK)) u_cause (
    .clk(clk), .por(por_i), .set_vec(set_vec),
    .clr_all(hit_clr && wdata_i[0]), .stat(stat_q)
  );

  // brownout interrupt
  logic irq_en, irq_st;
  rcc_bod_irq u_irq (
    .clk(clk), .por(por_i), .bod_i(bod_i),
    .en_wr(hit_ien), .set_wr(hit_iset), .clr_wr(hit_iclr),
    .wbit(wdata_i[0]), .en_q(irq_en), .st_q(irq_st), .irq_o(bod_irq_o)
  );

  // reset pulse outputs
  logic por_rst_q, poi_rst_q;
  always_ff @(posedge clk) begin
    if (por_i) begin
      por_rst_q <= 1'b1;
      poi_rst_q <= 1'b0;
    end else begin
      por_rst_q <= ext_rst_i || sys_req_i || bod_go || wdt_go || por_match;
      poi_rst_q <= poi_match || dbg_req_i;
    end
  end
  assign por_rst_o = por_rst_q;
  assign poi_rst_o = poi_rst_q;
  assign trc_rst_o = trc_q;

  // registered read
  logic [DATA_W-1:0] rd_mux, rdata_q;
  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(A_CFG):    rd_mux[1:0]    = cfg_q;
      ADDR_W'(A_CAUSE):  rd_mux[CN-1:0] = stat_q;
      ADDR_W'(A_TRC):    rd_mux[0]      = trc_q;
      ADDR_W'(A_IRQ_EN): rd_mux[0]      = irq_en;
      ADDR_W'(A_IRQ_ST): rd_mux[0]      = irq_st;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (por_i)        rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
    else              rdata_q <= '0;
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/rcc_top_chk.sv
module rcc_top_chk
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned KEY_W  = 8,
  parameter logic [KEY_W-1:0] POI_KEY = 'h1B,
  parameter logic [KEY_W-1:0] POR_KEY = 'hD4
) (
  input logic              clk,
  input logic              por_i,
  input logic              wdt_req_i,
  input logic              dbg_req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              por_rst_o,
  input logic              poi_rst_o,
  input logic              trc_rst_o,
  input logic              bod_irq_o,
  input logic [CAUSE_N-1:0] stat,
  input logic              wdt_en,
  input logic              irq_en
);
  logic por_key_wr, poi_key_wr, clr_wr, trc_wr, iset_wr;
  assign por_key_wr = wr_en_i && addr_i == ADDR_W'(A_POR_KEY) && wdata_i[KEY_W-1:0] == POR_KEY;
  assign poi_key_wr = wr_en_i && addr_i == ADDR_W'(A_POI_KEY) && wdata_i[KEY_W-1:0] == POI_KEY;
  assign clr_wr     = wr_en_i && addr_i == ADDR_W'(A_CAUSE_CL) && wdata_i[0];
  assign trc_wr     = wr_en_i && addr_i == ADDR_W'(A_TRC);
  assign iset_wr    = wr_en_i && addr_i == ADDR_W'(A_IRQ_SET) && wdata_i[0];

  // R1
  pwr_state_chk: assert property (@(posedge clk)
    por_i |=> (stat == CAUSE_N'(2) && !trc_rst_o && !bod_irq_o && !poi_rst_o && por_rst_o));

  // R2
  por_key_chk: assert property (@(posedge clk) disable iff (por_i)
    por_key_wr |=> (por_rst_o && stat[C_SWR]));

  // R3
  poi_key_chk: assert property (@(posedge clk) disable iff (por_i)
    poi_key_wr |=> (poi_rst_o && stat[C_POI]));

  // R3
  poi_quiet_chk: assert property (@(posedge clk) disable iff (por_i)
    (!poi_key_wr && !dbg_req_i) |=> !poi_rst_o);

  // R5
  wdt_fire_chk: assert property (@(posedge clk) disable iff (por_i)
    (wdt_req_i && wdt_en) |=> (por_rst_o && stat[C_WDT]));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (por_i)
    !clr_wr |=> ((stat & $past(stat)) == $past(stat)));

  // R8
  trc_level_chk: assert property (@(posedge clk) disable iff (por_i)
    trc_wr |=> (trc_rst_o == $past(wdata_i[0])));

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (por_i)
    iset_wr |=> (bod_irq_o == irq_en));

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (por_i)
    !rd_en_i |=> (rdata_o == '0));
endmodule

bind rcc_top rcc_top_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
  .POI_KEY(POI_KEY), .POR_KEY(POR_KEY)
) u_chk (
  .clk(clk), .por_i(por_i), .wdt_req_i(wdt_req_i), .dbg_req_i(dbg_req_i),
  .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i),
  .rdata_o(rdata_o), .por_rst_o(por_rst_o), .poi_rst_o(poi_rst_o),
  .trc_rst_o(trc_rst_o), .bod_irq_o(bod_irq_o),
  .stat(stat_q), .wdt_en(cfg_q.wdt_en), .irq_en(irq_en)
);

// File: tb/sim_rcc_top.sv
`timescale 1ns/1ps
module sim_rcc_top;
  logic        clk = 1'b0;
  logic        por_i = 1'b1;
  logic        ext_rst_i = 1'b0, bod_i = 1'b0, wdt_req_i = 1'b0;
  logic        dbg_req_i = 1'b0, sys_req_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        por_rst_o, poi_rst_o, trc_rst_o, bod_irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rcc_top u0 (
    .clk(clk), .por_i(por_i), .ext_rst_i(ext_rst_i), .bod_i(bod_i),
    .wdt_req_i(wdt_req_i), .dbg_req_i(dbg_req_i), .sys_req_i(sys_req_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rd_en_i(rd_en_i),
    .rdata_o(rdata_o), .por_rst_o(por_rst_o), .poi_rst_o(poi_rst_o),
    .trc_rst_o(trc_rst_o), .bod_irq_o(bod_irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [31:0] rd_model(input logic [11:0] a);
    case (a)
      12'h000: return 32'h3;  // both enables set
      12'h00C: return 32'h1;  // external cause only
      12'h014: return 32'h1;
      12'h200: return 32'h1;
      12'h204: return 32'h1;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    por_i = 1'b0;
    // R1 reset state
    chk("R1 por_rst during power-on", {31'b0, por_rst_o}, 32'h1);
    chk("R1 poi_rst", {31'b0, poi_rst_o}, 32'h0);
    chk("R1 trc_rst", {31'b0, trc_rst_o}, 32'h0);
    chk("R1 irq", {31'b0, bod_irq_o}, 32'h0);
    rd(12'h00C, v); chk("R1 cause", v, 32'h2);
    rd(12'h000, v); chk("R1 cfg", v, 32'h0);
    rd(12'h204, v); chk("R1 irq status", v, 32'h0);
    chk("R1 por_rst released", {31'b0, por_rst_o}, 32'h0);

    // R2 sweep of the POR key
    for (int k = 0; k < 256; k++) begin
      wr(12'h010, 32'h1);
      wr(12'h008, {24'hA5C3F0, 8'(k)});
      chk("R2 por pulse", {31'b0, por_rst_o}, {31'b0, k == 8'hD4});
      chk("R2 no poi", {31'b0, poi_rst_o}, 32'h0);
      @(negedge clk);
      chk("R2 single cycle", {31'b0, por_rst_o}, 32'h0);
      rd(12'h00C, v);
      chk("R2 cause bit3", v, (k == 8'hD4) ? 32'h8 : 32'h0);
    end

    // R3 sweep of the POI key
    for (int k = 0; k < 256; k++) begin
      wr(12'h010, 32'h1);
      wr(12'h004, {24'h5A3C0F, 8'(k)});
      chk("R3 poi pulse", {31'b0, poi_rst_o}, {31'b0, k == 8'h1B});
      chk("R3 no por", {31'b0, por_rst_o}, 32'h0);
      @(negedge clk);
      chk("R3 single cycle", {31'b0, poi_rst_o}, 32'h0);
      rd(12'h00C, v);
      chk("R3 cause bit4", v, (k == 8'h1B) ? 32'h10 : 32'h0);
    end

    // R4 ungated hardware sources
    for (int s = 0; s < 3; s++) begin
      wr(12'h010, 32'h1);
      @(negedge clk);
      ext_rst_i = (s == 0); sys_req_i = (s == 1); dbg_req_i = (s == 2);
      @(negedge clk);
      ext_rst_i = 0; sys_req_i = 0; dbg_req_i = 0;
      chk("R4 por_rst", {31'b0, por_rst_o}, {31'b0, s != 2});
      chk("R4 poi_rst", {31'b0, poi_rst_o}, {31'b0, s == 2});
      rd(12'h00C, v);
      chk("R4 cause", v, (s == 0) ? 32'h1 : (s == 1) ? 32'h8 : 32'h20);
    end

    // R5 / R6 enables crossed with watchdog and brownout
    for (int e = 0; e < 4; e++) begin
      for (int src = 0; src < 2; src++) begin
        wr(12'h000, 32'(e));
        wr(12'h010, 32'h1);
        @(negedge clk);
        if (src == 0) wdt_req_i = 1'b1; else bod_i = 1'b1;
        @(negedge clk);
        wdt_req_i = 1'b0; bod_i = 1'b0;
        if (src == 0) begin
          chk("R5 wdt reset", {31'b0, por_rst_o}, {31'b0, e[1]});
          rd(12'h00C, v); chk("R5 wdt cause", v, e[1] ? 32'h40 : 32'h0);
        end else begin
          chk("R6 bod reset", {31'b0, por_rst_o}, {31'b0, e[0]});
          rd(12'h00C, v); chk("R6 bod cause", v, e[0] ? 32'h4 : 32'h0);
        end
      end
    end
    wr(12'h000, 32'h0);

    // R7 sticky causes, clear collisions
    wr(12'h010, 32'h1);
    @(negedge clk); ext_rst_i = 1'b1; @(negedge clk); ext_rst_i = 1'b0;
    @(negedge clk); dbg_req_i = 1'b1; @(negedge clk); dbg_req_i = 1'b0;
    repeat (3) @(negedge clk);
    rd(12'h00C, v); chk("R7 accumulate", v, 32'h21);
    wr(12'h010, 32'hFFFF_FFFE);
    rd(12'h00C, v); chk("R7 write zero ignored", v, 32'h21);
    @(negedge clk);
    ext_rst_i = 1'b1; wr_en_i = 1'b1; addr_i = 12'h010; wdata_i = 32'h1;
    @(negedge clk);
    ext_rst_i = 1'b0; wr_en_i = 1'b0;
    rd(12'h00C, v); chk("R7 set beats clear", v, 32'h1);
    wr(12'h010, 32'h1);
    rd(12'h00C, v); chk("R7 cleared", v, 32'h0);

    // R8 trace reset level
    wr(12'h014, 32'h1);
    repeat (4) @(negedge clk);
    chk("R8 held", {31'b0, trc_rst_o}, 32'h1);
    wr(12'h014, 32'h0);
    chk("R8 released", {31'b0, trc_rst_o}, 32'h0);

    // R9 brownout interrupt
    wr(12'h208, 32'h1);
    rd(12'h204, v); chk("R9 cleared", v, 32'h0);
    wr(12'h20C, 32'h1);
    rd(12'h204, v); chk("R9 set reg", v, 32'h1);
    chk("R9 masked", {31'b0, bod_irq_o}, 32'h0);
    wr(12'h200, 32'h1);
    chk("R9 enabled", {31'b0, bod_irq_o}, 32'h1);
    wr(12'h208, 32'h1);
    chk("R9 clear", {31'b0, bod_irq_o}, 32'h0);
    @(negedge clk); bod_i = 1'b1; @(negedge clk);
    chk("R9 bod edge", {31'b0, bod_irq_o}, 32'h1);
    wr(12'h208, 32'h1);
    repeat (3) @(negedge clk);
    chk("R9 level no re-trigger", {31'b0, bod_irq_o}, 32'h0);
    @(negedge clk);
    bod_i = 1'b0; wr_en_i = 1'b1; addr_i = 12'h208; wdata_i = 32'h1;
    @(negedge clk);
    bod_i = 1'b1;  // edge coincides with a further clear below
    @(negedge clk);
    wr_en_i = 1'b0;
    chk("R9 set beats clear", {31'b0, bod_irq_o}, 32'h1);
    bod_i = 1'b0;

    // R10 full read sweep at a known state
    wr(12'h000, 32'h3);
    wr(12'h014, 32'h1);
    wr(12'h20C, 32'h1);
    wr(12'h010, 32'h1);
    @(negedge clk); ext_rst_i = 1'b1; @(negedge clk); ext_rst_i = 1'b0;
    for (int a = 0; a < 1024; a++) begin
      rd(12'(a * 4), v);
      chk($sformatf("R10 read %03h", a * 4), v, rd_model(12'(a * 4)));
    end
    @(negedge clk);
    chk("R10 idle zero", rdata_o, 32'h0);

    // R1 power-on again clears everything
    @(negedge clk); por_i = 1'b1; @(negedge clk); por_i = 1'b0;
    chk("R1 trc after power-on", {31'b0, trc_rst_o}, 32'h0);
    chk("R1 irq after power-on", {31'b0, bod_irq_o}, 32'h0);
    rd(12'h00C, v); chk("R1 cause after power-on", v, 32'h2);
    rd(12'h000, v); chk("R1 cfg after power-on", v, 32'h0);
    rd(12'h200, v); chk("R1 irq enable after power-on", v, 32'h0);

    summary();
  end
endmodule